// File: doc/BRIEF.md
# Normalizing Sequential Divider

This block divides one unsigned n-bit integer by another over several clock cycles and returns an integer quotient and remainder. When a start request arrives while the unit is idle, it captures both operands. In that same cycle it counts the leading zeros of the divisor and left-justifies the divisor so that its top bit is one. It then runs a shift-and-subtract loop. The loop has one iteration per clock, and the number of iterations is one more than the leading-zero count, so small divisors take more cycles than large ones.

Each iteration compares the partial remainder with the normalized divisor. When the partial remainder is not below the divisor, the divisor is subtracted and a quotient bit of one is recorded. The partial remainder then moves left by one place and takes in a zero from the right. After the last iteration, a finishing cycle shifts the partial remainder right by the leading-zero count to undo the normalization. It then publishes the results and raises a single-cycle completion pulse.

A zero divisor skips the loop. The unit then reports an all-ones quotient, returns the dividend as the remainder, and raises a divide-by-zero flag together with the completion pulse.

Top module: `norm_divider`

## Requirements
- R1: For a nonzero divisor, the results published with the completion pulse satisfy dividend = divisor × quotient + remainder, with remainder < divisor.
- R2: The completion output `done` is high for exactly one cycle. For a nonzero divisor with z leading zeros, it is high in the cycle after the (z+2)-th rising edge that follows the edge sampling `start`.
- R3: A zero divisor gives `done` and `divZero` high together in the cycle after the first edge following the start edge, with `quotient` all ones and `remainder` equal to the dividend.
- R4: `divZero` is low on every completion whose divisor is nonzero.
- R5: `start` is ignored while an operation is in progress: the result and its timing are those of the operation already under way.
- R6: `quotient` and `remainder` change only in the cycle in which `done` is high. Between completions they hold their values, whatever the operand inputs do.
- R7: A dividend smaller than the divisor gives quotient 0 and a remainder equal to the dividend. A zero dividend gives 0 and 0.
- R8: While iterating, the normalized divisor has its top bit set and the partial remainder being compared is below twice the normalized divisor. A divisor that already has its top bit set completes after a single iteration.
- R9: During and right after a synchronous reset (`rst` high), `done`, `divZero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; taken only while idle |
| dividend | input | WIDTH | Unsigned dividend, captured with start |
| divisor | input | WIDTH | Unsigned divisor, captured with start |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | High with done when the divisor was zero |
| quotient | output | WIDTH | Quotient of the latest completed operation |
| remainder | output | WIDTH | Remainder of the latest completed operation |

## Verification
The checker captures the operands in the cycle in which `start` is accepted. Its result checks are therefore valid only if the dividend and divisor present in that cycle are the ones the results should be compared against. The stimulus drives operands and `start` together on the falling edge and raises `start` only while the unit is idle, except in the deliberate busy-collision test. In that test the extra request carries different operands, and both the checker and the bench expect them to be discarded. The loop invariants assume only that the divisor is nonzero whenever iterations run; the vectors include zero divisors to show that the loop is then bypassed.

// File: rtl/norm_div_pkg.sv
package norm_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } divState_t;

  typedef struct packed {
    logic load;      // capture operands, normalize divisor
    logic step;      // one compare/subtract/shift iteration
    logic lastStep;  // final iteration: no left shift afterwards
    logic finish;    // denormalize and publish results
  } divStrobe_t;

endpackage

// File: rtl/norm_div_lzc.sv
module norm_div_lzc #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] value,
  output logic [CNT_W-1:0] zeros
);

  // Priority scan from the top bit: count zeros until the first one.
  always_comb begin
    logic found;
    found = 1'b0;
    zeros = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!found) begin
        if (value[i]) found = 1'b1;
        else          zeros = zeros + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/norm_div_datapath.sv
module norm_div_datapath
  import norm_div_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobe_t       strobe,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [CNT_W-1:0] lzNow,
  output logic             zeroNow,
  output logic             zeroHeld,
  output logic [WIDTH:0]   partRemObs,
  output logic [WIDTH-1:0] normDivObs,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  logic [WIDTH-1:0] normDiv;
  logic [WIDTH:0]   partRem;
  logic [WIDTH-1:0] quoReg;
  logic [CNT_W-1:0] shiftAmt;
  logic [WIDTH-1:0] dvdSave;
  logic             zeroDiv;

  logic [WIDTH:0]   diff;
  logic             geq;
  logic [WIDTH-1:0] nextRem;

  norm_div_lzc #(.WIDTH(WIDTH)) i_lzc (
    .value(divisor),
    .zeros(lzNow)
  );

  assign zeroNow = (divisor == '0);

  // Compare/subtract on a WIDTH+1 bit partial remainder.
  always_comb begin
    diff    = partRem - {1'b0, normDiv};
    geq     = (partRem >= {1'b0, normDiv});
    nextRem = geq ? diff[WIDTH-1:0] : partRem[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      normDiv   <= '0;
      partRem   <= '0;
      quoReg    <= '0;
      shiftAmt  <= '0;
      dvdSave   <= '0;
      zeroDiv   <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (strobe.load) begin
        normDiv  <= divisor << lzNow;
        partRem  <= {1'b0, dividend};
        quoReg   <= '0;
        shiftAmt <= lzNow;
        dvdSave  <= dividend;
        zeroDiv  <= zeroNow;
      end
      if (strobe.step) begin
        quoReg <= {quoReg[WIDTH-2:0], geq};
        if (strobe.lastStep) partRem <= {1'b0, nextRem};
        else                 partRem <= {nextRem, 1'b0};
      end
      if (strobe.finish) begin
        if (zeroDiv) begin
          quotient  <= '1;
          remainder <= dvdSave;
        end else begin
          quotient  <= quoReg;
          remainder <= partRem[WIDTH-1:0] >> shiftAmt;
        end
      end
    end
  end

  assign zeroHeld   = zeroDiv;
  assign partRemObs = partRem;
  assign normDivObs = normDiv;

endmodule

// File: rtl/norm_div_ctrl.sv
module norm_div_ctrl
  import norm_div_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] lzNow,
  input  logic             zeroNow,
  input  logic             zeroHeld,
  output divStrobe_t       strobe,
  output logic             idle,
  output logic             done,
  output logic             divZero
);

  divState_t        state;
  logic [CNT_W-1:0] iterLeft;

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && start;
    strobe.step     = (state == ST_RUN);
    strobe.lastStep = (state == ST_RUN) && (iterLeft == '0);
    strobe.finish   = (state == ST_FINISH);
  end

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
      divZero  <= 1'b0;
    end else begin
      done    <= strobe.finish;
      divZero <= strobe.finish && zeroHeld;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            iterLeft <= lzNow;
            state    <= zeroNow ? ST_FINISH : ST_RUN;
          end
        end
        ST_RUN: begin
          if (strobe.lastStep) state <= ST_FINISH;
          else                 iterLeft <= iterLeft - CNT_W'(1);
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/norm_divider.sv
module norm_divider
  import norm_div_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic             divZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divStrobe_t       strobe;
  logic [CNT_W-1:0] lzNow;
  logic             zeroNow;
  logic             zeroHeld;
  logic             idleNow;
  logic             stepNow;
  logic [WIDTH:0]   partRemObs;
  logic [WIDTH-1:0] normDivObs;

  norm_div_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lzNow    (lzNow),
    .zeroNow  (zeroNow),
    .zeroHeld (zeroHeld),
    .strobe   (strobe),
    .idle     (idleNow),
    .done     (done),
    .divZero  (divZero)
  );

  norm_div_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .dividend   (dividend),
    .divisor    (divisor),
    .lzNow      (lzNow),
    .zeroNow    (zeroNow),
    .zeroHeld   (zeroHeld),
    .partRemObs (partRemObs),
    .normDivObs (normDivObs),
    .quotient   (quotient),
    .remainder  (remainder)
  );

  assign stepNow = strobe.step;

endmodule

// File: rtl/norm_divider_chk.sv
module norm_divider_chk #(
  parameter int WIDTH = 8,
  localparam int W2 = 2 * WIDTH,
  localparam int BC_W = $clog2(WIDTH + 2) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             done,
  input logic             divZero,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             idleNow,
  input logic             stepNow,
  input logic [WIDTH:0]   partRemObs,
  input logic [WIDTH-1:0] normDivObs
);

  logic [WIDTH-1:0] savedDvd;
  logic [WIDTH-1:0] savedDiv;
  logic [BC_W-1:0]  busyCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      savedDvd <= '0;
      savedDiv <= '0;
      busyCnt  <= '0;
    end else begin
      if (idleNow && start) begin
        savedDvd <= dividend;
        savedDiv <= divisor;
      end
      busyCnt <= idleNow ? '0 : busyCnt + BC_W'(1);
    end
  end

  a_r1_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !divZero) |->
      ((W2'(quotient) * W2'(savedDiv) + W2'(remainder)) == W2'(savedDvd))
      && (remainder < savedDiv));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_busy_bound: assert property (@(posedge clk) disable iff (rst)
    !idleNow |-> (busyCnt <= BC_W'(WIDTH)));

  a_r3_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    divZero |-> done);

  a_r3_zero_result: assert property (@(posedge clk) disable iff (rst)
    (done && divZero) |-> ((quotient == '1) && (remainder == savedDvd)));

  a_r4_no_flag: assert property (@(posedge clk) disable iff (rst)
    (done && (savedDiv != '0)) |-> !divZero);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  a_r8_norm_msb: assert property (@(posedge clk) disable iff (rst)
    stepNow |-> normDivObs[WIDTH-1]);

  a_r8_rem_bound: assert property (@(posedge clk) disable iff (rst)
    stepNow |-> (partRemObs < {normDivObs, 1'b0}));

endmodule

bind norm_divider norm_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .dividend   (dividend),
  .divisor    (divisor),
  .done       (done),
  .divZero    (divZero),
  .quotient   (quotient),
  .remainder  (remainder),
  .idleNow    (idleNow),
  .stepNow    (stepNow),
  .partRemObs (partRemObs),
  .normDivObs (normDivObs)
);

// File: tb/test_norm_divider.sv
`timescale 1ns/1ps
module test_norm_divider;

  localparam int W = 8;
  localparam int NVEC = 13;
  // {dividend, divisor}
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    16'h1D04, 16'hFF01, 16'hFFFF, 16'h0007, 16'h0509, 16'h8080, 16'hC803,
    16'h640A, 16'h0101, 16'hFE7F, 16'h4D00, 16'h0000, 16'hFF80
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         done;
  logic         divZero;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  norm_divider #(.WIDTH(W)) i_norm_divider (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .done(done), .divZero(divZero),
    .quotient(quotient), .remainder(remainder)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lzCount(input logic [W-1:0] v);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  // Run one operation; optionally inject a colliding start while busy (R5).
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input string req, input bit collide);
    int k;
    int expQ, expR, expLat;
    bit expZ;
    if (b == 0) begin
      expQ = (1 << W) - 1; expR = a; expLat = 1; expZ = 1'b1;
    end else begin
      expQ = a / b; expR = a % b; expLat = lzCount(b) + 2; expZ = 1'b0;
    end
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 64) begin
      if (collide && k == 1) begin
        dividend = 8'd9; divisor = 8'd2; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); k++;
      @(negedge clk);
    end
    start = 1'b0;
    check(k == expLat, "R2", "latency", k, expLat);
    check(quotient == W'(expQ), req, "quotient", int'(quotient), expQ);
    check(remainder == W'(expR), req, "remainder", int'(remainder), expR);
    check(divZero == expZ, expZ ? "R3" : "R4", "divZero", int'(divZero), int'(expZ));
    @(posedge clk);
    @(negedge clk);
    check(!done, "R2", "done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(done == 0 && divZero == 0, "R9", "flags in reset", int'({done, divZero}), 0);
    check(quotient == 0 && remainder == 0, "R9", "results in reset",
          int'({quotient, remainder}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && quotient == 0 && remainder == 0, "R9", "after release",
          int'({done, quotient, remainder}), 0);

    // Vector table: R1 general, plus R3/R7/R8 corner entries
    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] a, b;
      string tag;
      a = VEC[i][2*W-1:W];
      b = VEC[i][W-1:0];
      if (b == 0)            tag = "R3";
      else if (a < b)        tag = "R7";
      else if (b[W-1])       tag = "R8";
      else                   tag = "R1";
      runOp(a, b, tag, 1'b0);
    end

    // R5: colliding start while busy is discarded
    runOp(8'd200, 8'd3, "R5", 1'b1);

    // R6: outputs hold with changing inputs and no start
    begin
      logic [W-1:0] q0, r0;
      q0 = quotient; r0 = remainder;
      for (int j = 0; j < 6; j++) begin
        dividend = W'(j * 37 + 11); divisor = W'(j + 1);
        @(posedge clk);
        @(negedge clk);
        check(quotient == q0, "R6", "quotient hold", int'(quotient), int'(q0));
        check(remainder == r0, "R6", "remainder hold", int'(remainder), int'(r0));
        check(!done, "R6", "no spurious done", int'(done), 0);
      end
    end

    // R7: zero dividend with largest iteration count
    runOp(8'd0, 8'd1, "R7", 1'b0);
    // R8: top bit set divisor, single iteration, large dividend
    runOp(8'd254, 8'd255, "R8", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule